// File: doc/BRIEF.md
# Conditional Register Move Unit

This block decides whether a conditional register-to-register move is allowed to write its destination, and produces the write request for the register file. Each request arrives as a strobed 32-bit instruction word. With it come the value of the source register, the value of the test register, the current contents of the destination register and an 8-bit vector of floating-point condition flags. Two kinds of move are recognised. A zero-test move looks at whether the test register is zero. A flag-test move looks at one condition flag, picked by an instruction field, and compares it with a sense bit.

The decision is combinational. It is captured in one register stage, so the result appears one clock after the strobe together with a valid flag. When the condition fails, the write enable stays low and the data output carries the old destination value, so a downstream write port can never store a partial result. Destination index 0 never produces a write, because that register is hard-wired.

Top module: `cmov_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` and `wr_en` are 0.
- R2: `out_valid` is 1 in exactly the cycles that follow a cycle with `in_valid` high. `wr_en` is never 1 while `out_valid` is 0.
- R3: An instruction with bits 31:26 = 0 and bits 5:0 = 6'h0A is a move-if-zero: `wr_en` = 1 and `wr_data` = `src_val` when `test_val` is 0.
- R4: An instruction with bits 31:26 = 0 and bits 5:0 = 6'h0B is a move-if-nonzero: `wr_en` = 1 and `wr_data` = `src_val` when `test_val` is not 0.
- R5: An instruction with bits 31:26 = 0 and bits 5:0 = 6'h01 is a flag move. Bits 20:18 select the flag `fcc[idx]`. Bit 16 is the sense: with sense 0 the move writes when the flag is 0, and with sense 1 it writes when the flag is 1.
- R6: `wr_idx` equals instruction bits 15:11. When that index is 0, `wr_en` is 0 whatever the condition.
- R7: When a recognised move's condition fails, `wr_en` = 0 and `wr_data` = `old_dst`.
- R8: Any other instruction word (nonzero bits 31:26 or another function code) gives `wr_en` = 0 and `wr_data` = `old_dst`.
- R9: In a cycle after `in_valid` was low, `wr_idx` and `wr_data` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word |
| src_val | input | 32 | Value read from the source register |
| test_val | input | 32 | Value read from the test register |
| old_dst | input | 32 | Current value of the destination register |
| fcc | input | 8 | Floating-point condition flags |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| wr_en | output | 1 | Destination write enable |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 32 | Data for the destination port |

## Verification
The assertions assume that `in_valid` and the operand inputs are known, stable values at each rising edge after reset, and that `old_dst` really is the current destination value. The scoreboard driver changes inputs only on the falling edge, so every request is settled before the capture edge. It inserts idle cycles between bursts so that the hold behaviour can be seen. Condition-flag vectors and operand values are drawn at random, but the driver forces the zero and nonzero test cases and walks all eight flag positions explicitly.

// File: rtl/cmov_pkg.sv
package cmov_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;
  localparam int CC_W    = 3;
  localparam int CC_NUM  = 1 << CC_W;

  localparam int OPC_HI  = 31;
  localparam int OPC_LO  = 26;
  localparam int DST_HI  = 15;
  localparam int DST_LO  = 11;
  localparam int CCI_HI  = 20;
  localparam int CCI_LO  = 18;
  localparam int SENSE_B = 16;

  localparam logic [5:0] FN_FLAG    = 6'h01;
  localparam logic [5:0] FN_IF_ZERO = 6'h0A;
  localparam logic [5:0] FN_IF_NZ   = 6'h0B;

  typedef enum logic [1:0] {
    MV_NONE    = 2'd0,
    MV_IF_ZERO = 2'd1,
    MV_IF_NZ   = 2'd2,
    MV_IF_FLAG = 2'd3
  } mv_kind_e;
endpackage

// File: rtl/cmov_decode.sv
module cmov_decode
  import cmov_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output mv_kind_e           kind,
  output logic [IDX_W-1:0]   dst_idx,
  output logic [CC_W-1:0]    cc_idx,
  output logic               sense
);
  logic       grp_ok;
  logic [2:0] fn_hi;
  logic [2:0] fn_lo;

  always_comb begin
    grp_ok  = (instr[OPC_HI:OPC_LO] == '0);
    fn_hi   = instr[5:3];
    fn_lo   = instr[2:0];
    dst_idx = instr[DST_HI:DST_LO];
    cc_idx  = instr[CCI_HI:CCI_LO];
    sense   = instr[SENSE_B];
    kind    = MV_NONE;
    if (grp_ok) begin
      if ({fn_hi, fn_lo} == FN_IF_ZERO)      kind = MV_IF_ZERO;
      else if ({fn_hi, fn_lo} == FN_IF_NZ)   kind = MV_IF_NZ;
      else if ({fn_hi, fn_lo} == FN_FLAG)    kind = MV_IF_FLAG;
    end
  end
endmodule

// File: rtl/cmov_eval.sv
module cmov_eval
  import cmov_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  mv_kind_e          kind,
  input  logic [DATA_W-1:0] test_val,
  input  logic [CC_NUM-1:0] fcc,
  input  logic [CC_W-1:0]   cc_idx,
  input  logic              sense,
  input  logic [IDX_W-1:0]  dst_idx,
  output logic              take
);
  logic is_zero;
  logic flag_bit;
  logic cond;

  always_comb begin
    is_zero  = (test_val == '0);
    flag_bit = fcc[cc_idx];
    unique case (kind)
      MV_IF_ZERO: cond = is_zero;
      MV_IF_NZ:   cond = !is_zero;
      MV_IF_FLAG: cond = (flag_bit == sense);
      default:    cond = 1'b0;
    endcase
    take = cond && (dst_idx != '0);
  end
endmodule

// File: rtl/cmov_unit.sv
module cmov_unit
  import cmov_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [DATA_W-1:0]    src_val,
  input  logic [DATA_W-1:0]    test_val,
  input  logic [DATA_W-1:0]    old_dst,
  input  logic [CC_NUM-1:0]    fcc,
  output logic                 out_valid,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [DATA_W-1:0]    wr_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok_n = rst_sync_q[1];

  mv_kind_e          kind;
  logic [IDX_W-1:0]  dst_idx;
  logic [CC_W-1:0]   cc_idx;
  logic              sense;
  logic              take;

  cmov_decode u_dec (
    .instr   (instr),
    .kind    (kind),
    .dst_idx (dst_idx),
    .cc_idx  (cc_idx),
    .sense   (sense)
  );

  cmov_eval #(.DATA_W(DATA_W)) u_eval (
    .kind     (kind),
    .test_val (test_val),
    .fcc      (fcc),
    .cc_idx   (cc_idx),
    .sense    (sense),
    .dst_idx  (dst_idx),
    .take     (take)
  );

  // next-state
  logic              vld_d, en_d, cap_en;
  logic [IDX_W-1:0]  idx_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    vld_d  = in_valid;
    en_d   = in_valid && take;
    cap_en = in_valid;
    idx_d  = dst_idx;
    data_d = take ? src_val : old_dst;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
    end else begin
      out_valid <= vld_d;
      wr_en     <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      wr_idx  <= '0;
      wr_data <= '0;
    end else if (cap_en) begin
      wr_idx  <= idx_d;
      wr_data <= data_d;
    end
  end

  // checks
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !in_valid |=> !out_valid);
  assert_en_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    wr_en |-> out_valid);
  assert_no_zero_dest_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    wr_en |-> (wr_idx != '0));
  assert_nz_blocks_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (in_valid && kind == MV_IF_ZERO && test_val != '0) |=> !wr_en);
  assert_zero_blocks_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (in_valid && kind == MV_IF_NZ && test_val == '0) |=> !wr_en);
  assert_write_src_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (in_valid && take) |=> (wr_data == $past(src_val)));
  assert_keep_old_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (in_valid && !take) |=> (wr_data == $past(old_dst) && !wr_en));
  assert_other_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (in_valid && kind == MV_NONE) |=> !wr_en);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !in_valid |=> ($stable(wr_data) && $stable(wr_idx)));
endmodule

// File: tb/cmov_unit_test.sv
module cmov_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, src_val = '0, test_val = '0, old_dst = '0;
  logic [7:0]  fcc = '0;
  logic        out_valid, wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;

  always #2 clk = ~clk;

  cmov_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_val(src_val), .test_val(test_val), .old_dst(old_dst), .fcc(fcc),
    .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  typedef struct {
    logic        en;
    logic [4:0]  idx;
    logic [31:0] data;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_cmp = 0, n_bad = 0;
  logic [31:0] last_data = '0;
  logic [4:0]  last_idx = '0;
  logic        seen = 1'b0;
  bit          done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [5:0] fn,
                                     input logic [2:0] ci, input logic tf,
                                     input logic [4:0] dst);
    logic [31:0] w;
    w = $urandom;
    w[31:26] = opc;
    w[5:0]   = fn;
    w[20:18] = ci;
    w[16]    = tf;
    w[15:11] = dst;
    return w;
  endfunction

  // expected result straight from the requirements
  task automatic drive(input logic [31:0] w, input logic [31:0] s, input logic [31:0] t,
                       input logic [31:0] o, input logic [7:0] f, input string req);
    exp_t e;
    logic c;
    c = 1'b0;
    if (w[31:26] == 6'd0) begin
      if (w[5:0] == 6'h0A)      c = (t == 0);
      else if (w[5:0] == 6'h0B) c = (t != 0);
      else if (w[5:0] == 6'h01) c = (f[w[20:18]] == w[16]);
    end
    if (w[15:11] == 5'd0) c = 1'b0;
    e.en = c; e.idx = w[15:11]; e.data = c ? s : o; e.req = req;
    @(negedge clk);
    in_valid = 1'b1; instr = w; src_val = s; test_val = t; old_dst = o; fcc = f;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      instr = $urandom; src_val = $urandom; test_val = $urandom; old_dst = $urandom;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && !done) begin
        if (out_valid) begin
          if (sb.size() == 0) begin
            check("R2 unexpected valid", 32'd1, 32'd0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check({e.req, " wr_en"}, {31'd0, wr_en}, {31'd0, e.en});
            check({e.req, " wr_idx R6"}, {27'd0, wr_idx}, {27'd0, e.idx});
            check({e.req, " wr_data"}, wr_data, e.data);
          end
          last_data = wr_data; last_idx = wr_idx; seen = 1'b1;
        end else begin
          check("R2 wr_en without valid", {31'd0, wr_en}, 32'd0);
          if (sb.size() != 0) check("R2 missing valid", 32'd0, 32'd1);
          if (seen) begin
            check("R9 data hold", wr_data, last_data);
            check("R9 idx hold", {27'd0, wr_idx}, {27'd0, last_idx});
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 wr_en in reset", {31'd0, wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 wr_en after reset", {31'd0, wr_en}, 32'd0);
    repeat (3) @(negedge clk);

    // R3 move-if-zero
    drive(mk(6'd0, 6'h0A, 3'd0, 1'b0, 5'd7), 32'hAAAA0001, 32'd0, 32'h11110000, 8'h00, "R3 zero");
    drive(mk(6'd0, 6'h0A, 3'd0, 1'b0, 5'd7), 32'hAAAA0002, 32'd1, 32'h11110001, 8'h00, "R7 R3 nonzero");
    drive(mk(6'd0, 6'h0A, 3'd0, 1'b0, 5'd31), 32'hAAAA0003, 32'h80000000, 32'h11110002, 8'h00, "R7 R3 msb");
    idle(2);
    // R4 move-if-nonzero
    drive(mk(6'd0, 6'h0B, 3'd0, 1'b0, 5'd3), 32'hBBBB0001, 32'h80000000, 32'h22220000, 8'h00, "R4 nonzero");
    drive(mk(6'd0, 6'h0B, 3'd0, 1'b0, 5'd3), 32'hBBBB0002, 32'd0, 32'h22220001, 8'h00, "R7 R4 zero");
    idle(1);
    // R5 flag moves, every index, both senses
    for (int i = 0; i < 8; i++) begin
      drive(mk(6'd0, 6'h01, 3'(i), 1'b1, 5'd9), 32'hC0 + 32'(i), 32'd5, 32'hD0 + 32'(i), 8'(1 << i), "R5 sense1 set");
      drive(mk(6'd0, 6'h01, 3'(i), 1'b0, 5'd9), 32'hE0 + 32'(i), 32'd5, 32'hF0 + 32'(i), 8'(1 << i), "R5 R7 sense0 set");
      drive(mk(6'd0, 6'h01, 3'(i), 1'b0, 5'd10), 32'h1C0 + 32'(i), 32'd0, 32'h1D0 + 32'(i), ~8'(1 << i), "R5 sense0 clear");
    end
    idle(2);
    // R6 destination 0
    drive(mk(6'd0, 6'h0A, 3'd0, 1'b0, 5'd0), 32'h12345678, 32'd0, 32'h0, 8'h00, "R6 dest zero");
    drive(mk(6'd0, 6'h01, 3'd2, 1'b1, 5'd0), 32'h12345679, 32'd0, 32'h0, 8'hFF, "R6 dest zero flag");
    // R8 other words
    drive(mk(6'd1, 6'h0A, 3'd0, 1'b0, 5'd4), 32'h55, 32'd0, 32'h66, 8'h00, "R8 other group");
    drive(mk(6'd0, 6'h0C, 3'd0, 1'b0, 5'd4), 32'h57, 32'd0, 32'h68, 8'hFF, "R8 other fn");
    drive(mk(6'd0, 6'h09, 3'd0, 1'b0, 5'd4), 32'h59, 32'd0, 32'h6A, 8'hFF, "R8 other fn2");
    idle(3);
    // mixed random traffic
    for (int k = 0; k < 200; k++) begin
      logic [5:0] fn;
      logic [31:0] t;
      case ($urandom % 4)
        0: fn = 6'h0A;
        1: fn = 6'h0B;
        2: fn = 6'h01;
        default: fn = 6'($urandom);
      endcase
      t = ($urandom % 2) ? 32'd0 : $urandom;
      drive(mk(($urandom % 8 == 0) ? 6'd2 : 6'd0, fn, 3'($urandom), 1'($urandom),
               5'($urandom)), $urandom, t, $urandom, 8'($urandom), "R3 R4 R5 R8 mixed");
      if ($urandom % 5 == 0) idle(1 + $urandom % 2);
    end
    idle(4);
    if (sb.size() != 0) check("R2 leftover", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule